// File: doc/BRIEF.md
# Write-Only Two-Wire Serial Slave Receiver

This block is the receive side of a two-wire serial slave running in a system clock domain that is much faster than the serial clock. It brings the clock and data lines through synchronizers and finds bus start and stop conditions in the synchronized levels. It shifts in bytes on clock rising edges and acknowledges by driving an open-drain enable. It answers to two addresses. The first is its own 7-bit address, built from a fixed 4-bit prefix parameter and three strap inputs. The second is a broadcast sync address that is used as a quick command, in which the eighth bit carries a flag and does not give a direction.

After its own address arrives with the write bit clear, the block accepts up to three bytes: a command byte, a low data byte and a high data byte. Each one is acknowledged and presented with its position in the transfer. A transfer that carries only the command byte is a legal short form. When a start or stop condition ends a transfer, the block reports how many data bytes had been accepted, so logic downstream can tell a complete word write from one that was cut off. After a sync quick command is acknowledged, the block gives a one-cycle strobe with the flag bit on the rising clock edge of the acknowledge.

Top module: `smb_wr_slave`

## Requirements
- R1: A falling SDA while SCL is high gives one `start_pulse` cycle, and a rising SDA while SCL is high gives one `stop_pulse` cycle. Either one aborts any transfer in progress and releases `sda_oe`. At most one of `start_pulse`, `stop_pulse`, `byte_valid` and `sync_pulse` is high in any cycle.
- R2: A first frame equal to {PREFIX, addr_pins[2:0]} (MSB first) followed by a 0 write bit is acknowledged: `sda_oe` is 1 while SCL is high on the ninth clock.
- R3: A first frame with the eighth bit at 1 for the own address, or an address that matches neither address, is not acknowledged. No byte is then delivered or acknowledged until the next start or stop.
- R4: After an acknowledged own-address frame, each data byte is acknowledged and given out on `byte_data` (MSB received first) with a one-cycle `byte_valid` on the acknowledge clock's rising edge. `byte_index` is 0 for the command byte, 1 for the low byte and 2 for the high byte.
- R5: A fourth or later data byte in the same transfer is not acknowledged and raises no `byte_valid`.
- R6: The address 7'b1111110 is acknowledged whatever its eighth bit. On the rising clock edge of that acknowledge, `sync_pulse` is high for one cycle and `sync_bit` equals the eighth bit. Bytes that follow it in the same transfer are not acknowledged.
- R7: `sda_oe` changes only while SCL is low, and it is released after the falling edge that ends the ninth clock.
- R8: With each `start_pulse` or `stop_pulse`, `end_count` shows the number of data bytes (0 to 3) accepted in the transfer that just ended. A repeated start begins a new count from 0.
- R9: After reset, `sda_oe`, all pulses, `byte_data`, `byte_index`, `sync_bit` and `end_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_pins | input | 3 | Strap bits forming the low address bits |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| byte_valid | output | 1 | One-cycle strobe for an accepted data byte |
| byte_data | output | 8 | Accepted data byte |
| byte_index | output | 2 | Position: 0 command, 1 low data, 2 high data |
| start_pulse | output | 1 | Start condition seen |
| stop_pulse | output | 1 | Stop condition seen |
| end_count | output | 2 | Data bytes accepted by the transfer just ended |
| sync_pulse | output | 1 | Sync quick command acknowledged |
| sync_bit | output | 1 | Flag bit of the last sync quick command |

## Verification
The assertions check on every cycle that the acknowledge enable moves only while the clock line is low, that event strobes never overlap, that every delivered byte and sync strobe falls inside an acknowledge, that byte positions stay in range, and that a stop leaves the line released. Only the bench scenarios can show address matching against the strap pins, the rejection of read and foreign addresses, the three-byte limit, the flag value of sync commands, and the byte counts reported when a transfer is cut off by a repeated start or completes with a stop.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RX     = 2'd1,
    ST_ACK    = 2'd2,
    ST_IGNORE = 2'd3
  } smb_state_t;

  typedef enum logic [1:0] {
    MD_ADDR  = 2'd0,
    MD_WRITE = 2'd1,
    MD_SYNC  = 2'd2
  } smb_mode_t;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 7;
  localparam logic [ADDR_W-1:0] SYNC_ADDR = 7'b1111110;
  localparam int unsigned MAX_DATA  = 3;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  localparam int unsigned DEPTH = STAGES + 1;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [DEPTH-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[DEPTH-2:0], din[g]};
      end
      assign lvl[g]  = pipe_q[DEPTH-2];
      assign rise[g] = pipe_q[DEPTH-2] & ~pipe_q[DEPTH-1];
      assign fall[g] = ~pipe_q[DEPTH-2] & pipe_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/smb_shifter.sv
module smb_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     shift_en,
  input  logic                     bit_in,
  output logic [WIDTH-1:0]         data,
  output logic [$clog2(WIDTH+1)-1:0] cnt,
  output logic                     full
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] data_d;
  logic [CW-1:0]    cnt_d;

  assign full = (cnt == CW'(WIDTH));

  always_comb begin
    data_d = data;
    cnt_d  = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (shift_en && !full) begin
      data_d = {data[WIDTH-2:0], bit_in};
      cnt_d  = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      cnt  <= '0;
    end else begin
      data <= data_d;
      cnt  <= cnt_d;
    end
  end
endmodule

// File: rtl/smb_wr_slave.sv
module smb_wr_slave
  import smb_pkg::*;
#(
  parameter logic [3:0] PREFIX = 4'b0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_pins,
  output logic       sda_oe,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic [1:0] byte_index,
  output logic       start_pulse,
  output logic       stop_pulse,
  output logic [1:0] end_count,
  output logic       sync_pulse,
  output logic       sync_bit
);
  localparam int unsigned CW = $clog2(BYTE_W + 1);

  logic [1:0] lvl, rise, fall;
  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;

  smb_line_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk (clk), .rst_n(rst_n), .din({scl_i, sda_i}),
    .lvl (lvl), .rise(rise), .fall(fall)
  );
  assign {scl_lvl, sda_lvl}   = lvl;
  assign {scl_rise, sda_rise} = rise;
  assign {scl_fall, sda_fall} = fall;

  logic bus_start, bus_stop;
  assign bus_start = scl_lvl & sda_fall;
  assign bus_stop  = scl_lvl & sda_rise;

  logic              sh_clr, sh_en, sh_full;
  logic [BYTE_W-1:0] sh_data;
  logic [CW-1:0]     sh_cnt;

  smb_shifter #(.WIDTH(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en),
    .bit_in(sda_lvl), .data(sh_data), .cnt(sh_cnt), .full(sh_full)
  );

  logic [ADDR_W-1:0] own_addr;
  assign own_addr = {PREFIX, addr_pins};

  smb_state_t state_q, state_d;
  smb_mode_t  mode_q, mode_d;
  logic [1:0] idx_q, idx_d;
  logic       ack_addr_q, ack_addr_d;
  logic       oe_d, bv_d, sp_d, st_d, so_d, sbit_d;
  logic [1:0] endc_d;
  logic [7:0] bdata_d;
  logic [1:0] bidx_d;

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    idx_d      = idx_q;
    ack_addr_d = ack_addr_q;
    oe_d       = sda_oe;
    sbit_d     = sync_bit;
    endc_d     = end_count;
    bdata_d    = byte_data;
    bidx_d     = byte_index;
    bv_d       = 1'b0;
    sp_d       = 1'b0;
    st_d       = 1'b0;
    so_d       = 1'b0;
    sh_clr     = 1'b0;
    sh_en      = 1'b0;
    if (bus_start || bus_stop) begin
      state_d = bus_start ? ST_RX : ST_IDLE;
      mode_d  = MD_ADDR;
      endc_d  = idx_q;
      idx_d   = 2'd0;
      oe_d    = 1'b0;
      sh_clr  = 1'b1;
      st_d    = bus_start;
      so_d    = bus_stop;
    end else begin
      unique case (state_q)
        ST_RX: begin
          sh_en = scl_rise;
          if (scl_fall && sh_full) begin
            state_d = ST_IGNORE;
            if (mode_q == MD_ADDR) begin
              ack_addr_d = 1'b1;
              if (sh_data[7:1] == own_addr && !sh_data[0]) begin
                mode_d  = MD_WRITE;
                state_d = ST_ACK;
                oe_d    = 1'b1;
              end else if (sh_data[7:1] == SYNC_ADDR) begin
                mode_d  = MD_SYNC;
                sbit_d  = sh_data[0];
                state_d = ST_ACK;
                oe_d    = 1'b1;
              end
            end else if (mode_q == MD_WRITE && idx_q != 2'(MAX_DATA)) begin
              ack_addr_d = 1'b0;
              state_d    = ST_ACK;
              oe_d       = 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_rise) begin
            if (mode_q == MD_SYNC) begin
              sp_d = 1'b1;
            end else if (!ack_addr_q) begin
              bv_d    = 1'b1;
              bdata_d = sh_data;
              bidx_d  = idx_q;
              idx_d   = idx_q + 2'd1;
            end
          end
          if (scl_fall) begin
            oe_d    = 1'b0;
            sh_clr  = 1'b1;
            state_d = (mode_q == MD_SYNC) ? ST_IGNORE : ST_RX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= MD_ADDR;
      idx_q       <= 2'd0;
      ack_addr_q  <= 1'b0;
      sda_oe      <= 1'b0;
      byte_valid  <= 1'b0;
      byte_data   <= 8'd0;
      byte_index  <= 2'd0;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      end_count   <= 2'd0;
      sync_pulse  <= 1'b0;
      sync_bit    <= 1'b0;
    end else begin
      state_q     <= state_d;
      mode_q      <= mode_d;
      idx_q       <= idx_d;
      ack_addr_q  <= ack_addr_d;
      sda_oe      <= oe_d;
      byte_valid  <= bv_d;
      byte_data   <= bdata_d;
      byte_index  <= bidx_d;
      start_pulse <= st_d;
      stop_pulse  <= so_d;
      end_count   <= endc_d;
      sync_pulse  <= sp_d;
      sync_bit    <= sbit_d;
    end
  end
endmodule

// File: rtl/smb_wr_slave_chk.sv
module smb_wr_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       byte_valid,
  input logic [1:0] byte_index,
  input logic       start_pulse,
  input logic       stop_pulse,
  input logic       sync_pulse
);
  // R7
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
  // R1
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, stop_pulse, byte_valid, sync_pulse}));
  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !sda_oe);
  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  // R4
  valid_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> sda_oe);
  // R4
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> byte_index != 2'd3);
  // R6
  sync_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> sda_oe);
endmodule

bind smb_wr_slave smb_wr_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .byte_valid(byte_valid), .byte_index(byte_index),
  .start_pulse(start_pulse), .stop_pulse(stop_pulse), .sync_pulse(sync_pulse)
);

// File: tb/smb_wr_slave_test.sv
`timescale 1ns/1ps
module smb_wr_slave_test;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] addr_pins = 3'b101;
  logic sda_oe, byte_valid, start_pulse, stop_pulse, sync_pulse, sync_bit;
  logic [7:0] byte_data;
  logic [1:0] byte_index, end_count;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  smb_wr_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_pins(addr_pins), .sda_oe(sda_oe), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_index(byte_index),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .end_count(end_count), .sync_pulse(sync_pulse), .sync_bit(sync_bit)
  );

  int checks = 0, failures = 0;
  int bv_cnt = 0, sp_cnt = 0, st_cnt = 0, so_cnt = 0, oe_viol = 0;
  logic [7:0] got [0:3];
  logic [1:0] last_idx;
  logic last_sbit, oe_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin got[byte_index] = byte_data; last_idx = byte_index; bv_cnt++; end
      if (sync_pulse) begin sp_cnt++; last_sbit = sync_bit; end
      if (start_pulse) st_cnt++;
      if (stop_pulse) so_cnt++;
      if (sda_oe != oe_prev && scl_m) oe_viol++;
      oe_prev = sda_oe;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(posedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    @(negedge clk); acked = sda_oe;
    scl_m = 1'b0; wq();
  endtask

  task automatic t_reset();
    chk(sda_oe == 0 && byte_valid == 0 && start_pulse == 0 && stop_pulse == 0,
        "R9 reset strobes", int'(sda_oe), 0);
    chk(byte_data == 0 && byte_index == 0 && end_count == 0 && sync_bit == 0,
        "R9 reset data", int'(byte_data), 0);
  endtask

  task automatic t_word();
    bit a; int b0 = bv_cnt, s0 = st_cnt, p0 = so_cnt;
    bus_start();
    chk(st_cnt == s0 + 1, "R1 start pulse", st_cnt - s0, 1);
    send(8'h4A, a); chk(a, "R2 own address ack", int'(a), 1);
    send(8'h07, a); chk(a && got[0] == 8'h07 && last_idx == 0, "R4 command byte", int'(got[0]), 7);
    send(8'hA5, a); chk(a && got[1] == 8'hA5 && last_idx == 1, "R4 low byte", int'(got[1]), 8'hA5);
    send(8'h03, a); chk(a && got[2] == 8'h03 && last_idx == 2, "R4 high byte", int'(got[2]), 3);
    chk(bv_cnt == b0 + 3, "R4 byte count", bv_cnt - b0, 3);
    send(8'h55, a);
    chk(!a && bv_cnt == b0 + 3, "R5 fourth byte refused", int'(a), 0);
    bus_stop();
    chk(so_cnt == p0 + 1 && !sda_oe, "R1 stop pulse", so_cnt - p0, 1);
    chk(end_count == 2'd3, "R8 full word count", int'(end_count), 3);
  endtask

  task automatic t_foreign();
    bit a; int b0 = bv_cnt;
    bus_start();
    send(8'h4C, a); chk(!a, "R3 foreign address no ack", int'(a), 0);
    send(8'h11, a); chk(!a && bv_cnt == b0, "R3 ignored after mismatch", bv_cnt - b0, 0);
    bus_stop();
    chk(end_count == 2'd0, "R8 zero count", int'(end_count), 0);
    bus_start();
    send(8'h4B, a); chk(!a, "R3 read bit no ack", int'(a), 0);
    send(8'h22, a); chk(!a && bv_cnt == b0, "R3 ignored after read", bv_cnt - b0, 0);
    bus_stop();
  endtask

  task automatic t_sync();
    bit a; int s0 = sp_cnt, b0 = bv_cnt;
    bus_start();
    send(8'hFD, a);
    chk(a && sp_cnt == s0 + 1 && last_sbit == 1'b1, "R6 sync flag one", int'(last_sbit), 1);
    send(8'h33, a); chk(!a && bv_cnt == b0, "R6 nothing after sync", int'(a), 0);
    bus_stop();
    bus_start();
    send(8'hFC, a);
    chk(a && sp_cnt == s0 + 2 && last_sbit == 1'b0, "R6 sync flag zero", int'(last_sbit), 0);
    bus_stop();
  endtask

  task automatic t_cut();
    bit a; int s0;
    bus_start();
    send(8'h4A, a); send(8'h11, a);
    chk(a && got[0] == 8'h11, "R4 send byte command", int'(got[0]), 8'h11);
    s0 = st_cnt;
    bus_start();
    chk(st_cnt == s0 + 1 && end_count == 2'd1, "R8 cut after command", int'(end_count), 1);
    send(8'h4A, a); send(8'h21, a); send(8'h42, a);
    bus_start();
    chk(end_count == 2'd2, "R8 cut after low byte", int'(end_count), 2);
    addr_pins = 3'b010;
    send(8'h4A, a); chk(!a, "R2 strap change old address", int'(a), 0);
    bus_start();
    send(8'h44, a); chk(a, "R2 strap change new address", int'(a), 1);
    bus_stop();
    chk(end_count == 2'd0, "R8 restart count", int'(end_count), 0);
    chk(oe_viol == 0, "R7 oe moves only with scl low", oe_viol, 0);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk); t_reset();
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        t_word();
        t_foreign();
        t_sync();
        t_cut();
        done = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; failures++;
          $display("FAIL watchdog actual=0 expected=1");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule